// File: doc/BRIEF.md
# Per-Lane Link Event Counter

This block counts how often one chosen event occurs on one chosen lane of a serial-link controller. The controller supplies a bank of single-cycle event strobes, one per supported event code per lane. A register port selects the event code and the lane, switches counting on or off through a three-bit encoded enable field, and can zero the count. The count is read back from a separate data register.

Software programs the control word with a code, a lane and the "on" enable value, then reads the data register later to obtain the number of strobe cycles seen on that one source. An unsupported code or an unimplemented lane leaves the counter idle. The selection can be moved while the counter is running, and the running total is kept. The count stops at all-ones and does not wrap.

Top module: `lane_evt_counter`

## Requirements
- R1: After a synchronous reset the control word reads 0x00000000, the data register reads 0, and the read data output is 0.
- R2: The control register is at offset 0x08. Bits 27:16 hold the event code, bits 11:8 the lane and bits 4:2 the enable field, and all three read back as written. Bits 31:28, 15:12 and 6:5 read as zero.
- R3: The counter advances only while the enable field holds 3. The value 1, and every other value, stops counting and keeps the current count.
- R4: A control write whose bits 1:0 equal 1 zeroes the count at that write, and a strobe in the same cycle is not added. The values 0, 2 and 3 do not clear. Bits 1:0 always read back as 0.
- R5: Bit 7 is read-only. It reads 1 exactly when the enable field is 3 and the selected code and lane are both supported. Writes to bit 7 have no effect.
- R6: Strobe input bit `lane*31 + idx` is routed to the counter. Here idx = code-0x600 for codes 0x600..0x606 and idx = code-0x700+7 for codes 0x700..0x717. Strobes at any other position never change the count.
- R7: A code outside those two ranges, or a lane number at or above NUM_LANES, never increments the counter, even with every strobe high.
- R8: While counting, each clock edge with the selected strobe high adds exactly 1. The count reads from offset 0x0C, zero-extended to 32 bits.
- R9: The count saturates at all-ones (2^CNT_W-1) and holds there under further strobes.
- R10: A control write that changes the code or lane while counting, with clear bits not equal to 1, keeps the count. From the next clock on, only the newly selected strobe counts.
- R11: The read data updates one clock after a read request and holds between requests. Offsets other than 0x08 and 0x0C read 0. Writes to 0x0C and to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | NUM_LANES*31 | Per-lane event strobes, bit lane*31+idx |
| reg_wr_en | input | 1 | Register write request |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench sweeps every lane up to two beyond the implemented count against every supported code and the codes just outside each range. For each pair it checks both the count and the status bit. A misrouted index or a wrong range bound would count the wrong strobe, or would count on an invalid selection. A clear issued while the strobe is high must leave zero; a design that let the increment win would show 1. The non-clearing values 2 and 3 and the non-"on" enable values 1, 5 and 7 must leave the count untouched. A reduced counter width drives the count to all-ones, where a wrapping design would fall back to a small value. A selection change in mid-run must keep the running total, which catches designs that clear on reselection.

// File: rtl/lec_pkg.sv
package lec_pkg;

  // supported event code groups
  localparam logic [11:0] GRP_A_BASE = 12'h600;
  localparam int          GRP_A_CNT  = 7;
  localparam logic [11:0] GRP_B_BASE = 12'h700;
  localparam int          GRP_B_CNT  = 24;
  localparam int          NUM_EVT    = GRP_A_CNT + GRP_B_CNT;
  localparam int          EVT_IDX_W  = $clog2(NUM_EVT);

  // register map (byte offsets)
  localparam logic [7:0]  OFS_CTRL   = 8'h08;
  localparam logic [7:0]  OFS_DATA   = 8'h0C;

  // enable / clear encodings
  localparam logic [2:0]  EN_ON      = 3'd3;
  localparam logic [1:0]  CLR_GO     = 2'd1;

  // control word field positions
  localparam int CODE_LSB = 16;
  localparam int CODE_W   = 12;
  localparam int LANE_LSB = 8;
  localparam int LANE_W   = 4;
  localparam int STAT_BIT = 7;
  localparam int EN_LSB   = 2;
  localparam int EN_W     = 3;
  localparam int CLR_LSB  = 0;
  localparam int CLR_W    = 2;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [LANE_W-1:0] lane;
    logic [EN_W-1:0]   en;
  } lec_ctrl_t;

  typedef struct packed {
    logic                 ok;
    logic [EVT_IDX_W-1:0] idx;
  } lec_map_t;

  // translate an event code into a dense strobe index
  function automatic lec_map_t lec_map_code(input logic [CODE_W-1:0] code);
    lec_map_t m;
    logic [CODE_W-1:0] off_a;
    logic [CODE_W-1:0] off_b;
    off_a = code - GRP_A_BASE;
    off_b = code - GRP_B_BASE;
    m.ok  = 1'b0;
    m.idx = '0;
    if (code >= GRP_A_BASE && off_a < CODE_W'(GRP_A_CNT)) begin
      m.ok  = 1'b1;
      m.idx = EVT_IDX_W'(off_a);
    end else if (code >= GRP_B_BASE && off_b < CODE_W'(GRP_B_CNT)) begin
      m.ok  = 1'b1;
      m.idx = EVT_IDX_W'(off_b + CODE_W'(GRP_A_CNT));
    end
    return m;
  endfunction

endpackage

// File: rtl/lec_ctrl_regs.sv
module lec_ctrl_regs
  import lec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output lec_ctrl_t         ctrl_q,
  output logic              clr_pulse
);

  logic ctrl_hit;
  logic unused_wbits;

  assign ctrl_hit  = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign clr_pulse = ctrl_hit && (wdata[CLR_LSB +: CLR_W] == CLR_GO);

  // bits with no storage (status is derived, clear is a pulse)
  assign unused_wbits = ^{wdata[31:28], wdata[15:12], wdata[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_hit) begin
      ctrl_q.code <= wdata[CODE_LSB +: CODE_W];
      ctrl_q.lane <= wdata[LANE_LSB +: LANE_W];
      ctrl_q.en   <= wdata[EN_LSB +: EN_W];
    end
  end

endmodule

// File: rtl/lec_event_route.sv
module lec_event_route
  import lec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int STRB_W   = NUM_LANES * NUM_EVT
) (
  input  logic [STRB_W-1:0] evt_strobe,
  input  logic [CODE_W-1:0] code,
  input  logic [LANE_W-1:0] lane,
  output logic              sel_ok,
  output logic              hit
);

  lec_map_t             map;
  logic                 lane_ok;
  logic [NUM_LANES-1:0] per_lane;

  assign map     = lec_map_code(code);
  assign lane_ok = ({1'b0, lane} < (LANE_W+1)'(NUM_LANES));
  assign sel_ok  = map.ok && lane_ok;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [NUM_EVT-1:0] slice;
    assign slice       = evt_strobe[l*NUM_EVT +: NUM_EVT];
    assign per_lane[l] = (lane == LANE_W'(l)) && slice[map.idx];
  end

  assign hit = sel_ok && (|per_lane);

endmodule

// File: rtl/lec_sat_counter.sv
module lec_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  logic at_max;
  assign at_max = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !at_max) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
  import lec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  localparam int STRB_W   = NUM_LANES * NUM_EVT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STRB_W-1:0] evt_strobe,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  lec_ctrl_t        ctrl_q;
  logic             clr_pulse;
  logic             sel_ok;
  logic             hit;
  logic             active;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      ctrl_word;

  lec_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .ctrl_q    (ctrl_q),
    .clr_pulse (clr_pulse)
  );

  lec_event_route #(.NUM_LANES(NUM_LANES)) u_route (
    .evt_strobe (evt_strobe),
    .code       (ctrl_q.code),
    .lane       (ctrl_q.lane),
    .sel_ok     (sel_ok),
    .hit        (hit)
  );

  assign active = (ctrl_q.en == EN_ON) && sel_ok;

  lec_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_pulse),
    .inc   (active && hit),
    .cnt_q (cnt_q)
  );

  assign ctrl_word = {4'b0, ctrl_q.code, 4'b0, ctrl_q.lane,
                      active, 2'b0, ctrl_q.en, 2'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      if (reg_addr == ADDR_W'(OFS_CTRL)) begin
        reg_rdata <= ctrl_word;
      end else if (reg_addr == ADDR_W'(OFS_DATA)) begin
        reg_rdata <= 32'(cnt_q);
      end else begin
        reg_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             active,
  input logic             sel_ok,
  input logic             hit,
  input logic [CNT_W-1:0] cnt
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (cnt == '0));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !clr) |=> $stable(cnt));

  // R7
  bad_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_ok && !clr) |=> $stable(cnt));

  // R6
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr) |=> $stable(cnt));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((&cnt) && !clr) |=> (&cnt));

endmodule

bind lane_evt_counter lec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clr    (clr_pulse),
  .active (active),
  .sel_ok (sel_ok),
  .hit    (hit),
  .cnt    (cnt_q)
);

// File: tb/lane_evt_counter_tb.sv
module lane_evt_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int CW = 8;
  localparam int NE = 31;
  localparam int SW = NL * NE;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_DATA = 8'h0C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] strobe = '0;
  logic          reg_wr_en = 1'b0;
  logic          reg_rd_en = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  lane_evt_counter #(.NUM_LANES(NL), .CNT_W(CW), .ADDR_W(8)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .evt_strobe (strobe),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int code_idx(input int code);
    if (code >= 'h600 && code <= 'h606) return code - 'h600;
    if (code >= 'h700 && code <= 'h717) return code - 'h700 + 7;
    return -1;
  endfunction

  function automatic logic [31:0] cword(input int code, input int lane, input int en, input int clr);
    return (32'(code) << 16) | (32'(lane) << 8) | (32'(en) << 2) | 32'(clr);
  endfunction

  function automatic logic [31:0] rb(input int code, input int lane, input int en, input bit st);
    return (32'(code) << 16) | (32'(lane) << 8) | (32'(en) << 2) | (32'(st) << 7);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    v = reg_rdata;
  endtask

  task automatic hold(input int b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe[b] = 1'b1;
    end
    @(negedge clk);
    strobe = '0;
  endtask

  task automatic hold_all(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe = '1;
    end
    @(negedge clk);
    strobe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata after reset", reg_rdata, 32'h0);
    rd(A_CTRL, v); check("R1 ctrl after reset", v, 32'h0);
    rd(A_DATA, v); check("R1 count after reset", v, 32'h0);

    // R6 / R7 / R2 / R5 sweep over lanes and codes
    for (int lane = 0; lane < NL + 2; lane++) begin
      for (int k = 0; k < 35; k++) begin
        int code, idx, n;
        bit valid;
        code  = (k < 9) ? ('h5FF + k) : ('h6FF + k - 9);
        idx   = code_idx(code);
        valid = (idx >= 0) && (lane < NL);
        n     = 1 + (code % 3);
        wr(A_CTRL, cword(code, lane, 3, 1));
        rd(A_CTRL, v);
        check($sformatf("R2 R5 ctrl readback code=%0h lane=%0d", code, lane), v, rb(code, lane, 3, valid));
        if (valid) begin
          hold((lane*NE + idx + 1) % SW, 2);   // R6 neighbour strobe must not count
          hold(lane*NE + idx, n);
          rd(A_DATA, v);
          check($sformatf("R6 R8 count code=%0h lane=%0d", code, lane), v, 32'(n));
        end else begin
          hold_all(n);
          rd(A_DATA, v);
          check($sformatf("R7 invalid code=%0h lane=%0d", code, lane), v, 32'h0);
        end
      end
    end

    // R3 enable encoding
    wr(A_CTRL, cword('h600, 0, 3, 1));
    hold(0, 4);
    rd(A_DATA, v); check("R3 counting on", v, 32'd4);
    wr(A_CTRL, cword('h600, 0, 1, 0));
    hold(0, 5);
    rd(A_DATA, v); check("R3 off value 1 keeps count", v, 32'd4);
    rd(A_CTRL, v); check("R5 status low when off", v, rb('h600, 0, 1, 0));
    wr(A_CTRL, cword('h600, 0, 5, 0));
    hold(0, 3);
    rd(A_DATA, v); check("R3 value 5 does not count", v, 32'd4);
    wr(A_CTRL, cword('h600, 0, 7, 0));
    hold(0, 3);
    rd(A_DATA, v); check("R3 value 7 does not count", v, 32'd4);
    wr(A_CTRL, cword('h600, 0, 3, 0));
    hold(0, 2);
    rd(A_DATA, v); check("R3 resume keeps total", v, 32'd6);

    // R4 clear encodings and priority
    wr(A_CTRL, cword('h600, 0, 3, 2));
    rd(A_DATA, v); check("R4 clear value 2 ignored", v, 32'd6);
    wr(A_CTRL, cword('h600, 0, 3, 3));
    rd(A_DATA, v); check("R4 clear value 3 ignored", v, 32'd6);
    rd(A_CTRL, v); check("R4 clear bits read zero", v, rb('h600, 0, 3, 1));
    @(negedge clk);
    strobe[0] = 1'b1;
    wr(A_CTRL, cword('h600, 0, 3, 1));
    strobe = '0;
    rd(A_DATA, v); check("R4 clear beats same-cycle strobe", v, 32'd0);

    // R5 write to status bit ignored
    wr(A_CTRL, cword('h600, 0, 1, 0) | 32'h80);
    rd(A_CTRL, v); check("R5 status bit not writable", v, rb('h600, 0, 1, 0));

    // R10 reselect while running
    wr(A_CTRL, cword('h600, 0, 3, 1));
    hold(0, 3);
    wr(A_CTRL, cword('h701, 1, 3, 0));
    rd(A_DATA, v); check("R10 reselect keeps count", v, 32'd3);
    hold(1*NE + 8, 2);
    rd(A_DATA, v); check("R10 new source counts", v, 32'd5);
    hold(0, 2);
    rd(A_DATA, v); check("R10 old source ignored", v, 32'd5);

    // R11 read port behaviour
    wr(A_DATA, 32'h55);
    rd(A_DATA, v); check("R11 data register write ignored", v, 32'd5);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R11 stray write ignored", v, rb('h701, 1, 3, 1));
    rd(8'h10, v); check("R11 unmapped offset reads zero", v, 32'h0);
    rd(8'h04, v); check("R11 unmapped offset 0x04 reads zero", v, 32'h0);
    rd(A_DATA, held);
    hold(1*NE + 8, 3);
    check("R11 rdata holds without request", reg_rdata, held);

    // R9 saturation
    wr(A_CTRL, cword('h717, 3, 3, 1));
    hold(3*NE + 30, 300);
    rd(A_DATA, v); check("R9 saturates at all-ones", v, 32'd255);
    hold(3*NE + 30, 3);
    rd(A_DATA, v); check("R9 holds at all-ones", v, 32'd255);
    wr(A_CTRL, cword('h717, 3, 3, 1));
    hold(3*NE + 30, 1);
    rd(A_DATA, v); check("R8 single step after clear", v, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule